// File: doc/BRIEF.md
# Aliased Video Register Bank

This block is the CPU-facing register store of a video peripheral that sits on an 8-bit processor bus with a 16-bit address. The system address decoder asserts one chip-select line for a 1 KiB window. The block then looks only at the six lowest address bits to choose one of 47 byte-wide registers. The four window bits above them are never examined, so the same register set answers at sixteen places, spaced 64 bytes apart. Only one physical copy of each register exists. A byte written through any of these places is seen through all of them.

A write takes effect on the rising clock edge of a valid bus cycle in which the block is selected and the read/write line is low. A read is combinational: while the block is selected and read/write is high, the selected register drives the read bus. Offsets that hold no register read as all ones.

Register 0 holds the horizontal position of the first sprite. It is compared at all times with an incoming horizontal beam counter. When the counter reaches that value, a one-cycle start strobe is raised.

Top module: `vrb_alias_bank`

## Requirements
- R1: A synchronous active-high reset clears all 47 registers (offsets 0x00 to 0x2E) to 0x00.
- R2: On a rising edge where bus_valid=1, cs=1 and rw=0, the register at offset addr[5:0] (when below 0x2F) takes the value of wdata.
- R3: No register changes on an edge where bus_valid=0 or cs=0, or where rw=1.
- R4: addr[9:6] has no effect. A write through any of the 16 aliases is returned by a read through every other alias at the same offset addr[5:0].
- R5: While cs=1 and rw=1, rdata equals the register at offset addr[5:0]. While cs=0 or rw=0, rdata is 0x00.
- R6: Offsets 0x2F to 0x3F read as 0xFF. Writes to them change no register.
- R7: spr_start is 1 in a cycle where hpos equals register 0 and hpos differs from its value in the previous cycle.
- R8: spr_start is 0 whenever hpos is unchanged from the previous cycle or differs from register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Bus cycle valid strobe |
| cs | input | 1 | Chip select for the whole 1 KiB window |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 10 | Address within the window; only bits [5:0] are decoded |
| wdata | input | 8 | Write data from the CPU |
| rdata | output | 8 | Read data, combinational |
| hpos | input | 8 | Horizontal beam counter |
| spr_start | output | 1 | Sprite 0 start strobe |

## Verification
The bench writes every register through one alias and reads it back through a different alias. A design that decoded any of bits 9:6 would return stale or reset data there. It writes into the unimplemented offsets and then reads the whole map. A decoder that wrapped those offsets onto real registers would corrupt register 0x00 or 0x2E, or would fail to return 0xFF. It issues cycles that look like writes but lack bus_valid or cs, and cycles with rw=0 but no valid strobe. A design with a missing qualifier would alter a register or leak data onto rdata. The beam counter is stepped up to the compare value, held there, moved away and then jumped back. This exposes a strobe that stays high while the counter is held, or one that misses a jump. It also exposes a comparator that keeps using the old position after register 0 is rewritten through a far alias.

// File: rtl/vrb_pkg.sv
package vrb_pkg;
  localparam int DATA_W = 8;
  localparam int OFF_W  = 6;
  localparam int ADDR_W = 10;
  localparam int NREG   = 47;

  function automatic logic [OFF_W-1:0] reg_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic off_present(input logic [OFF_W-1:0] o);
    return o < OFF_W'(NREG);
  endfunction

  function automatic logic beam_hit(input logic [DATA_W-1:0] h,
                                    input logic [DATA_W-1:0] h_prev,
                                    input logic [DATA_W-1:0] x);
    return (h == x) && (h != h_prev);
  endfunction
endpackage

// File: rtl/vrb_decode.sv
module vrb_decode
  import vrb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W,
  parameter int NR = NREG
) (
  input  logic          bus_valid,
  input  logic          cs,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  output logic [OW-1:0] off,
  output logic          off_impl,
  output logic          wr_fire,
  output logic          rd_sel,
  output logic [NR-1:0] wen
);
  logic alias_bits_unused;
  assign alias_bits_unused = ^addr[AW-1:OW];

  assign off      = addr[OW-1:0];
  assign off_impl = off < OW'(NR);
  assign wr_fire  = bus_valid & cs & ~rw;
  assign rd_sel   = cs & rw;

  for (genvar g = 0; g < NR; g++) begin : g_wen
    assign wen[g] = wr_fire && (off == OW'(g));
  end
endmodule

// File: rtl/vrb_regfile.sv
module vrb_regfile
  import vrb_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NR = NREG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NR-1:0]    wen,
  input  logic [DW-1:0]    wdata,
  output logic [NR*DW-1:0] reg_flat
);
  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)         q <= '0;
      else if (wen[g]) q <= wdata;
    end
    assign reg_flat[g*DW +: DW] = q;
  end
endmodule

// File: rtl/vrb_rdmux.sv
module vrb_rdmux
  import vrb_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int OW = OFF_W,
  parameter int NR = NREG
) (
  input  logic [NR*DW-1:0] reg_flat,
  input  logic [OW-1:0]    off,
  input  logic             off_impl,
  input  logic             rd_sel,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NR; i++) begin
      if (off == OW'(i)) picked = reg_flat[i*DW +: DW];
    end
  end

  assign rdata = !rd_sel  ? '0 :
                 off_impl ? picked : '1;
endmodule

// File: rtl/vrb_xcmp.sv
module vrb_xcmp
  import vrb_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic [DW-1:0] hpos,
  input  logic [DW-1:0] x0,
  output logic          xmatch,
  output logic          hmoved,
  output logic          spr_start
);
  logic [DW-1:0] hpos_prev;

  always_ff @(posedge clk) hpos_prev <= hpos;

  assign xmatch    = (hpos == x0);
  assign hmoved    = (hpos != hpos_prev);
  assign spr_start = xmatch & hmoved;
endmodule

// File: rtl/vrb_alias_bank.sv
module vrb_alias_bank
  import vrb_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W,
  parameter int NR = NREG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          cs,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] hpos,
  output logic          spr_start
);
  logic [OW-1:0]    off;
  logic             off_impl;
  logic             wr_fire;
  logic             rd_sel;
  logic [NR-1:0]    wen;
  logic [NR*DW-1:0] reg_flat;
  logic [DW-1:0]    x0;
  logic             xmatch;
  logic             hmoved;

  vrb_decode #(.AW(AW), .OW(OW), .NR(NR)) u_dec (
    .bus_valid(bus_valid), .cs(cs), .rw(rw), .addr(addr),
    .off(off), .off_impl(off_impl), .wr_fire(wr_fire),
    .rd_sel(rd_sel), .wen(wen)
  );

  vrb_regfile #(.DW(DW), .NR(NR)) u_rf (
    .clk(clk), .rst(rst), .wen(wen), .wdata(wdata), .reg_flat(reg_flat)
  );

  vrb_rdmux #(.DW(DW), .OW(OW), .NR(NR)) u_rd (
    .reg_flat(reg_flat), .off(off), .off_impl(off_impl),
    .rd_sel(rd_sel), .rdata(rdata)
  );

  assign x0 = reg_flat[DW-1:0];

  vrb_xcmp #(.DW(DW)) u_xc (
    .clk(clk), .hpos(hpos), .x0(x0),
    .xmatch(xmatch), .hmoved(hmoved), .spr_start(spr_start)
  );
endmodule

// File: rtl/vrb_checker.sv
module vrb_checker
  import vrb_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W,
  parameter int NR = NREG
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             cs,
  input logic             rw,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rdata,
  input logic [DW-1:0]    hpos,
  input logic             spr_start,
  input logic [NR*DW-1:0] reg_flat,
  input logic [DW-1:0]    x0
);
  localparam logic [OW-1:0] LIMIT = OW'(NR);

  function automatic logic [DW-1:0] pick(input logic [NR*DW-1:0] f,
                                         input logic [OW-1:0] o);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < NR; i++) if (o == OW'(i)) r = f[i*DW +: DW];
    return r;
  endfunction

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reg_flat == '0));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && cs && !rw && addr[OW-1:0] < LIMIT)
    |=> (pick(reg_flat, $past(addr[OW-1:0])) == $past(wdata)));

  p_no_write_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && cs && !rw) |=> $stable(reg_flat));

  p_read_alias_r4: assert property (@(posedge clk) disable iff (rst)
    (cs && rw && addr[OW-1:0] < LIMIT) |-> (rdata == pick(reg_flat, addr[OW-1:0])));

  p_read_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !(cs && rw) |-> (rdata == '0));

  p_unimpl_ones_r6: assert property (@(posedge clk) disable iff (rst)
    (cs && rw && addr[OW-1:0] >= LIMIT) |-> (rdata == '1));

  p_start_cause_r7: assert property (@(posedge clk) disable iff (rst)
    spr_start |-> (hpos == x0 && hpos != $past(hpos)));

  p_start_held_r8: assert property (@(posedge clk) disable iff (rst)
    (hpos == $past(hpos)) |-> !spr_start);
endmodule

bind vrb_alias_bank vrb_checker #(.DW(DW), .AW(AW), .OW(OW), .NR(NR)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .cs(cs), .rw(rw),
  .addr(addr), .wdata(wdata), .rdata(rdata), .hpos(hpos),
  .spr_start(spr_start), .reg_flat(reg_flat), .x0(x0)
);

// File: tb/vrb_alias_bank_tb.sv
module vrb_alias_bank_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_valid = 1'b0;
  logic       cs = 1'b0;
  logic       rw = 1'b1;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] hpos = '0;
  logic       spr_start;

  always #2 clk = ~clk;

  vrb_alias_bank u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .cs(cs), .rw(rw),
    .addr(addr), .wdata(wdata), .rdata(rdata), .hpos(hpos),
    .spr_start(spr_start)
  );

  typedef struct {
    bit         is_start;
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;
  logic [7:0] mdl [47];

  function automatic logic [9:0] mk(input int alias_n, input int off);
    return {4'(alias_n), 6'(off)};
  endfunction

  function automatic logic [7:0] expect_rd(input int off);
    return (off < 47) ? mdl[off] : 8'hFF;
  endfunction

  task automatic drive(input logic v, input logic c, input logic r,
                       input logic [9:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_valid = v; cs = c; rw = r; addr = a; wdata = d;
  endtask

  task automatic push(input bit s, input logic [7:0] v, input string t);
    exp_t e;
    e.is_start = s; e.val = v; e.tag = t;
    sb_q.push_back(e);
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    drive(1'b1, 1'b1, 1'b0, a, d);
    if (int'(a[5:0]) < 47) mdl[int'(a[5:0])] = d;
  endtask

  task automatic rd(input logic [9:0] a, input string t);
    drive(1'b1, 1'b1, 1'b1, a, 8'h00);
    push(1'b0, expect_rd(int'(a[5:0])), t);
  endtask

  task automatic fake_wr(input logic v, input logic c, input logic [9:0] a,
                         input logic [7:0] d, input string t);
    drive(v, c, 1'b0, a, d);
    if (v && c && int'(a[5:0]) < 47) mdl[int'(a[5:0])] = d;
    push(1'b0, 8'h00, t);
  endtask

  task automatic hstep(input logic [7:0] h, input bit e, input string t);
    drive(1'b0, 1'b0, 1'b1, 10'h000, 8'h00);
    hpos = h;
    push(1'b1, {7'd0, e}, t);
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      logic [7:0] act;
      e = sb_q.pop_front();
      act = e.is_start ? {7'd0, spr_start} : rdata;
      checks++;
      if (act !== e.val) begin
        errors++;
        $display("FAIL %s: actual %02h expected %02h", e.tag, act, e.val);
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 47; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 and R6: map after reset
    for (int o = 0; o < 64; o++) rd(mk(0, o), o < 47 ? "R1 reset value" : "R6 unimplemented reads ones");

    // R2 and R4: write through one alias, read through another
    for (int o = 0; o < 47; o++) wr(mk(o % 16, o), 8'((o * 37 + 11) ^ 8'h5A));
    for (int o = 0; o < 47; o++) rd(mk((o + 5) % 16, o), "R2 R4 alias readback");

    // R3 and R5: blocked write cycles, rdata low while not reading
    fake_wr(1'b0, 1'b1, mk(2, 3), 8'hAA, "R5 rdata zero on rw low");
    fake_wr(1'b1, 1'b0, mk(7, 3), 8'hBB, "R5 rdata zero when deselected");
    fake_wr(1'b0, 1'b0, mk(1, 0), 8'hCC, "R5 rdata zero idle");
    drive(1'b1, 1'b0, 1'b1, mk(4, 3), 8'h00);
    push(1'b0, 8'h00, "R5 rdata zero read while deselected");
    rd(mk(12, 3), "R3 offset 3 unchanged");
    rd(mk(3, 0), "R3 offset 0 unchanged");

    // R6: writes to unimplemented offsets are ignored
    for (int o = 47; o < 64; o++) wr(mk(o % 16, o), 8'h3C);
    for (int o = 0; o < 64; o++) rd(mk(15 - (o % 16), o), "R6 map after unimplemented writes");

    // R7 and R8: beam comparator
    wr(mk(9, 0), 8'h40);
    hstep(8'h3E, 1'b0, "R8 no match");
    hstep(8'h3F, 1'b0, "R8 no match");
    hstep(8'h40, 1'b1, "R7 start on arrival");
    hstep(8'h40, 1'b0, "R8 held counter");
    hstep(8'h41, 1'b0, "R8 moved past");
    hstep(8'h40, 1'b1, "R7 start on jump back");
    wr(mk(15, 0), 8'h80);
    hstep(8'h80, 1'b1, "R7 start after alias rewrite");
    hstep(8'h40, 1'b0, "R8 old position ignored");
    rd(mk(6, 0), "R4 position via alias");

    // R1: reset mid-run
    drive(1'b0, 1'b0, 1'b1, 10'h000, 8'h00);
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    for (int i = 0; i < 47; i++) mdl[i] = 8'h00;
    for (int o = 0; o < 47; o++) rd(mk(o % 16, o), "R1 cleared by reset");

    drive(1'b0, 1'b0, 1'b1, 10'h000, 8'h00);
    @(posedge clk); @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule